// File: doc/BRIEF.md
# Dead-Time Generator with Fault Shutdown

This block turns up to three pulse-width-modulated drive signals into complementary output pairs for half-bridge power stages. Each channel has a small state machine that opens a programmable gap on both edges of its input. When the input rises, the complementary output drops at once and the primary output follows only after the rise gap. When the input falls, the primary output drops at once and the complementary output follows only after the fall gap. Gaps are counted in ticks of a shared power-of-two prescaler. A pulse that ends before its gap has elapsed never reaches the output.

A fault unit watches four sources: processor lockup, debug halt and two external fault lines. Each source has its own enable. A flag is set when a source is active and enabled, and it stays set until a write-one-to-clear strobe removes it. While any flag is set, the selected action holds the outputs in a safe state. The action is one of: no action, force inactive, drive low, or release the pins. Configuration is written through a parallel load strobe. A key write can lock the configuration against change and a second key can unlock it. Channel 0 can take its drive from an alternate input.

Top module: `dtu_top`

## Requirements
- R1: After reset every channel is idle (primary inactive, complementary active), only pair 0 is enabled, the pin order is primaries [NCH-1:0] then complementaries [2*NCH-1:NCH], no fault flag is set, and the reset action is force-inactive.
- R2: When a channel input rises, its complementary output goes inactive on the next clock edge. The primary output becomes active only on the edge where the rise count, loaded on that first edge, has been decremented to one on a prescaler tick. A rise count of zero makes it active on the first edge.
- R3: Falling edges mirror R2 using the fall count. A primary and its complementary output are never active together.
- R4: An input pulse that ends while its gap is still counting returns the channel to its previous steady state, so that no output pulse appears.
- R5: The prescaler ticks once every 2^sel clocks. The select field cfg_presc takes values 0 to PS_MAX, and larger values are clamped to PS_MAX.
- R6: cfg_act_low inverts all six pins. cfg_cinv additionally inverts the complementary pins.
- R7: A pin whose bit in cfg_oen is 0 has pin_oe = 0 and pin_o = 0.
- R8: Flag bits are [0] lockup, [1] debug halt, [2] external line 0, [3] external line 1. A flag sets when its source is high and its cfg_src_en bit is 1. It stays set until a flag_clr_we pulse with a 1 in that mask bit. A source that is still active wins over the clear.
- R9: cfg_fault_act selects what happens while any flag is set: 0 no effect, 1 both members of each pair inactive (after polarity), 2 all pins driven 0, 3 all pin_oe 0.
- R10: With cfg_auto_restart set, the debug flag clears by itself on the clock after dbg_halt falls. Without it, the flag stays set.
- R11: key_we with key_val equal to LOCK_KEY makes later cfg_we writes have no effect. key_val equal to UNLOCK_KEY restores them. Any other key value changes nothing.
- R12: With cfg_alt_sel set, channel 0 follows alt_in instead of pwm_in[0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_in | input | NCH | Drive input per channel |
| alt_in | input | 1 | Alternate drive for channel 0 |
| cfg_we | input | 1 | Load all cfg_* fields |
| cfg_presc | input | $clog2(PS_MAX+1) | Prescaler exponent |
| cfg_rise | input | DT_W | Rise gap in ticks |
| cfg_fall | input | DT_W | Fall gap in ticks |
| cfg_act_low | input | 1 | Invert all pins |
| cfg_cinv | input | 1 | Extra inversion of complementary pins |
| cfg_alt_sel | input | 1 | Channel 0 uses alt_in |
| cfg_oen | input | 2*NCH | Per-pin enable |
| cfg_src_en | input | 4 | Per-source fault enable |
| cfg_fault_act | input | 2 | Fault action code |
| cfg_auto_restart | input | 1 | Clear debug flag on halt release |
| key_we | input | 1 | Key write strobe |
| key_val | input | KEY_W | Key value |
| core_lockup | input | 1 | Lockup fault source |
| dbg_halt | input | 1 | Debug halt fault source |
| ext_fault | input | 2 | External fault lines |
| flag_clr_we | input | 1 | Flag clear strobe |
| flag_clr_mask | input | 4 | Flags to clear |
| pin_o | output | 2*NCH | Pin values |
| pin_oe | output | 2*NCH | Pin drive enables |
| fault_flags | output | 4 | Sticky fault flags |

## Verification
The bench uses the default parameters: three channels, an 8-bit gap counter, PS_MAX of 10 and 16-bit keys. With PS_MAX at 10, the top divide-by-1024 setting can be reached within a short run. It is exercised with one-tick gaps against inputs held for 900 clocks, so that tick phase decides between suppressed and passed pulses. The 8-bit gap counter allows gaps longer than the one-clock pulses that the input patterns produce, which exercises suppression at prescaler setting 0. Every fault action, the set-wins clear and both key codes are reached with all six pins enabled.

// File: rtl/dtu_pkg.sv
package dtu_pkg;
    typedef enum logic [1:0] {
        CH_IDLE_LOW   = 2'd0,
        CH_RISE_GAP   = 2'd1,
        CH_DRIVE_HIGH = 2'd2,
        CH_FALL_GAP   = 2'd3
    } ch_state_e;

    typedef enum logic [1:0] {
        FA_NONE     = 2'd0,
        FA_INACTIVE = 2'd1,
        FA_CLEAR    = 2'd2,
        FA_TRISTATE = 2'd3
    } fault_act_e;

    localparam int NSRC       = 4;
    localparam int SRC_LOCKUP = 0;
    localparam int SRC_DEBUG  = 1;
    localparam int SRC_EXT0   = 2;
    localparam int SRC_EXT1   = 3;
endpackage

// File: rtl/dtu_prescaler.sv
module dtu_prescaler #(
    parameter int PS_MAX = 10,
    parameter int SEL_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int CNT_W = (PS_MAX > 0) ? PS_MAX : 1;

    logic [CNT_W-1:0] pcnt;
    logic [CNT_W-1:0] limit;
    logic [SEL_W-1:0] eff;

    always_comb begin
        eff   = (sel > SEL_W'(PS_MAX)) ? SEL_W'(PS_MAX) : sel;
        limit = CNT_W'((32'd1 << eff) - 32'd1);
        tick  = (pcnt >= limit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pcnt <= '0;
        else        pcnt <= tick ? '0 : pcnt + CNT_W'(1);
    end
endmodule

// File: rtl/dtu_chan.sv
module dtu_chan
    import dtu_pkg::*;
#(
    parameter int DT_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            drive,
    input  logic [DT_W-1:0] rise_gap,
    input  logic [DT_W-1:0] fall_gap,
    output logic            p_act,
    output logic            n_act
);
    ch_state_e       state, state_nx;
    logic [DT_W-1:0] cnt, cnt_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= CH_IDLE_LOW;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        unique case (state)
            CH_IDLE_LOW: if (drive) begin
                if (rise_gap == '0) state_nx = CH_DRIVE_HIGH;
                else begin
                    state_nx = CH_RISE_GAP;
                    cnt_nx   = rise_gap;
                end
            end
            CH_RISE_GAP: begin
                if (!drive) state_nx = CH_IDLE_LOW;
                else if (tick) begin
                    if (cnt == DT_W'(1)) state_nx = CH_DRIVE_HIGH;
                    else                 cnt_nx   = cnt - DT_W'(1);
                end
            end
            CH_DRIVE_HIGH: if (!drive) begin
                if (fall_gap == '0) state_nx = CH_IDLE_LOW;
                else begin
                    state_nx = CH_FALL_GAP;
                    cnt_nx   = fall_gap;
                end
            end
            CH_FALL_GAP: begin
                if (drive) state_nx = CH_DRIVE_HIGH;
                else if (tick) begin
                    if (cnt == DT_W'(1)) state_nx = CH_IDLE_LOW;
                    else                 cnt_nx   = cnt - DT_W'(1);
                end
            end
        endcase
    end

    always_comb begin
        unique case (state)
            CH_IDLE_LOW:   begin p_act = 1'b0; n_act = 1'b1; end
            CH_DRIVE_HIGH: begin p_act = 1'b1; n_act = 1'b0; end
            CH_RISE_GAP,
            CH_FALL_GAP:   begin p_act = 1'b0; n_act = 1'b0; end
        endcase
    end
endmodule

// File: rtl/dtu_fault.sv
module dtu_fault
    import dtu_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src,
    input  logic [NSRC-1:0] src_en,
    input  logic            clr_we,
    input  logic [NSRC-1:0] clr_mask,
    input  logic            auto_restart,
    output logic [NSRC-1:0] flags
);
    logic            dbg_q;
    logic [NSRC-1:0] flags_nx;

    always_comb begin
        flags_nx = (flags & ~(clr_we ? clr_mask : '0)) | (src & src_en);
        if (auto_restart && dbg_q && !src[SRC_DEBUG]) flags_nx[SRC_DEBUG] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags <= '0;
            dbg_q <= 1'b0;
        end else begin
            flags <= flags_nx;
            dbg_q <= src[SRC_DEBUG];
        end
    end
endmodule

// File: rtl/dtu_top.sv
module dtu_top
    import dtu_pkg::*;
#(
    parameter int               NCH        = 3,
    parameter int               DT_W       = 8,
    parameter int               PS_MAX     = 10,
    parameter int               KEY_W      = 16,
    parameter logic [KEY_W-1:0] LOCK_KEY   = 16'hA5E1,
    parameter logic [KEY_W-1:0] UNLOCK_KEY = 16'h1E5A
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NCH-1:0]               pwm_in,
    input  logic                         alt_in,
    input  logic                         cfg_we,
    input  logic [$clog2(PS_MAX+1)-1:0]  cfg_presc,
    input  logic [DT_W-1:0]              cfg_rise,
    input  logic [DT_W-1:0]              cfg_fall,
    input  logic                         cfg_act_low,
    input  logic                         cfg_cinv,
    input  logic                         cfg_alt_sel,
    input  logic [2*NCH-1:0]             cfg_oen,
    input  logic [3:0]                   cfg_src_en,
    input  logic [1:0]                   cfg_fault_act,
    input  logic                         cfg_auto_restart,
    input  logic                         key_we,
    input  logic [KEY_W-1:0]             key_val,
    input  logic                         core_lockup,
    input  logic                         dbg_halt,
    input  logic [1:0]                   ext_fault,
    input  logic                         flag_clr_we,
    input  logic [3:0]                   flag_clr_mask,
    output logic [2*NCH-1:0]             pin_o,
    output logic [2*NCH-1:0]             pin_oe,
    output logic [3:0]                   fault_flags
);
    localparam int SEL_W = $clog2(PS_MAX + 1);
    localparam int NOUT  = 2 * NCH;
    localparam logic [NOUT-1:0] OEN_RESET = NOUT'(1) | (NOUT'(1) << NCH);

    logic [SEL_W-1:0] presc_q;
    logic [DT_W-1:0]  rise_q, fall_q;
    logic             act_low_q, cinv_q, alt_q, auto_q, locked_q;
    logic [NOUT-1:0]  oen_q;
    logic [NSRC-1:0]  src_en_q;
    fault_act_e       act_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            presc_q   <= '0;
            rise_q    <= '0;
            fall_q    <= '0;
            act_low_q <= 1'b0;
            cinv_q    <= 1'b0;
            alt_q     <= 1'b0;
            oen_q     <= OEN_RESET;
            src_en_q  <= NSRC'(4'b0011);
            act_q     <= FA_INACTIVE;
            auto_q    <= 1'b0;
        end else if (cfg_we && !locked_q) begin
            presc_q   <= cfg_presc;
            rise_q    <= cfg_rise;
            fall_q    <= cfg_fall;
            act_low_q <= cfg_act_low;
            cinv_q    <= cfg_cinv;
            alt_q     <= cfg_alt_sel;
            oen_q     <= cfg_oen;
            src_en_q  <= cfg_src_en;
            act_q     <= fault_act_e'(cfg_fault_act);
            auto_q    <= cfg_auto_restart;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                locked_q <= 1'b0;
        else if (key_we && key_val == LOCK_KEY)    locked_q <= 1'b1;
        else if (key_we && key_val == UNLOCK_KEY)  locked_q <= 1'b0;
    end

    logic tick;
    dtu_prescaler #(.PS_MAX(PS_MAX), .SEL_W(SEL_W)) u_presc (
        .clk(clk), .rst_n(rst_n), .sel(presc_q), .tick(tick)
    );

    logic [NCH-1:0] drive, p_act, n_act;
    for (genvar g = 0; g < NCH; g++) begin : g_ch
        if (g == 0) begin : g_alt
            assign drive[g] = alt_q ? alt_in : pwm_in[g];
        end else begin : g_plain
            assign drive[g] = pwm_in[g];
        end
        dtu_chan #(.DT_W(DT_W)) u_chan (
            .clk(clk), .rst_n(rst_n), .tick(tick), .drive(drive[g]),
            .rise_gap(rise_q), .fall_gap(fall_q),
            .p_act(p_act[g]), .n_act(n_act[g])
        );
    end

    dtu_fault u_fault (
        .clk(clk), .rst_n(rst_n),
        .src({ext_fault[1], ext_fault[0], dbg_halt, core_lockup}),
        .src_en(src_en_q), .clr_we(flag_clr_we), .clr_mask(flag_clr_mask),
        .auto_restart(auto_q), .flags(fault_flags)
    );

    // Fault forcing sits after the channel state machines, which keep running.
    logic force_idle, force_zero, force_off;
    always_comb begin
        force_idle = 1'b0;
        force_zero = 1'b0;
        force_off  = 1'b0;
        unique case (act_q)
            FA_NONE:     ;
            FA_INACTIVE: force_idle = |fault_flags;
            FA_CLEAR:    force_zero = |fault_flags;
            FA_TRISTATE: force_off  = |fault_flags;
        endcase
    end

    always_comb begin
        for (int i = 0; i < NCH; i++) begin
            logic pr, nr, pv, nv, ep, en;
            pr = p_act[i] & ~force_idle;
            nr = n_act[i] & ~force_idle;
            pv = (pr ^ act_low_q) & ~force_zero;
            nv = (nr ^ act_low_q ^ cinv_q) & ~force_zero;
            ep = oen_q[i] & ~force_off;
            en = oen_q[i+NCH] & ~force_off;
            pin_o[i]      = pv & ep;
            pin_o[i+NCH]  = nv & en;
            pin_oe[i]     = ep;
            pin_oe[i+NCH] = en;
        end
    end
endmodule

// File: rtl/dtu_checker.sv
module dtu_checker
    import dtu_pkg::*;
#(
    parameter int NCH   = 3,
    parameter int DT_W  = 8,
    parameter int SEL_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2*NCH-1:0] pin_o,
    input logic [2*NCH-1:0] pin_oe,
    input logic [3:0]       fault_flags,
    input logic             flag_clr_we,
    input logic             act_low_q,
    input logic             cinv_q,
    input logic             alt_q,
    input logic             auto_q,
    input logic             locked_q,
    input logic [2*NCH-1:0] oen_q,
    input logic [3:0]       src_en_q,
    input logic [1:0]       act_q,
    input logic [SEL_W-1:0] presc_q,
    input logic [DT_W-1:0]  rise_q,
    input logic [DT_W-1:0]  fall_q
);
    assert_no_overlap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!act_low_q && !cinv_q) |-> ((pin_o[NCH-1:0] & pin_o[2*NCH-1:NCH]) == '0));

    assert_disabled_pin_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_oe & ~oen_q) == '0) && ((pin_o & ~pin_oe) == '0));

    assert_sticky_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_clr_we && !auto_q) |=> ((fault_flags & $past(fault_flags)) == $past(fault_flags)));

    assert_clear_action_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_flags != '0 && act_q == FA_CLEAR) |-> (pin_o == '0));

    assert_tristate_action_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_flags != '0 && act_q == FA_TRISTATE) |-> (pin_oe == '0));

    assert_locked_cfg_R11: assert property (@(posedge clk) disable iff (!rst_n)
        locked_q |=> $stable({presc_q, rise_q, fall_q, act_low_q, cinv_q, alt_q,
                              oen_q, src_en_q, act_q, auto_q}));
endmodule

bind dtu_top dtu_checker #(.NCH(NCH), .DT_W(DT_W), .SEL_W($clog2(PS_MAX+1))) u_dtu_chk (
    .clk(clk), .rst_n(rst_n), .pin_o(pin_o), .pin_oe(pin_oe),
    .fault_flags(fault_flags), .flag_clr_we(flag_clr_we),
    .act_low_q(act_low_q), .cinv_q(cinv_q), .alt_q(alt_q), .auto_q(auto_q),
    .locked_q(locked_q), .oen_q(oen_q), .src_en_q(src_en_q), .act_q(act_q),
    .presc_q(presc_q), .rise_q(rise_q), .fall_q(fall_q)
);

// File: tb/test_dtu_top.sv
module test_dtu_top;
    localparam logic [15:0] LK = 16'hA5E1;
    localparam logic [15:0] UK = 16'h1E5A;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] pwm_in = '0;
    logic       alt_in = 1'b0;
    logic       cfg_we = 1'b0;
    logic [3:0] cfg_presc = '0;
    logic [7:0] cfg_rise = '0, cfg_fall = '0;
    logic       cfg_act_low = 1'b0, cfg_cinv = 1'b0, cfg_alt_sel = 1'b0, cfg_auto_restart = 1'b0;
    logic [5:0] cfg_oen = '0;
    logic [3:0] cfg_src_en = '0;
    logic [1:0] cfg_fault_act = '0;
    logic        key_we = 1'b0;
    logic [15:0] key_val = '0;
    logic        core_lockup = 1'b0, dbg_halt = 1'b0;
    logic [1:0]  ext_fault = '0;
    logic        flag_clr_we = 1'b0;
    logic [3:0]  flag_clr_mask = '0;
    logic [5:0]  pin_o, pin_oe;
    logic [3:0]  fault_flags;

    dtu_top i_dtu_top (
        .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .alt_in(alt_in), .cfg_we(cfg_we),
        .cfg_presc(cfg_presc), .cfg_rise(cfg_rise), .cfg_fall(cfg_fall),
        .cfg_act_low(cfg_act_low), .cfg_cinv(cfg_cinv), .cfg_alt_sel(cfg_alt_sel),
        .cfg_oen(cfg_oen), .cfg_src_en(cfg_src_en), .cfg_fault_act(cfg_fault_act),
        .cfg_auto_restart(cfg_auto_restart), .key_we(key_we), .key_val(key_val),
        .core_lockup(core_lockup), .dbg_halt(dbg_halt), .ext_fault(ext_fault),
        .flag_clr_we(flag_clr_we), .flag_clr_mask(flag_clr_mask),
        .pin_o(pin_o), .pin_oe(pin_oe), .fault_flags(fault_flags)
    );

    always #4 clk = ~clk;

    int    vectors = 0, miscompares = 0;
    string phase = "R1";

    // Behavioural reference: channel phase 0 idle, 1 rising gap, 2 high, 3 falling gap.
    int       m_st[3] = '{0, 0, 0};
    int       m_cnt[3] = '{0, 0, 0};
    int       m_pc = 0, m_presc = 0, m_rise = 0, m_fall = 0, m_act = 1;
    bit       m_al = 0, m_ci = 0, m_alt = 0, m_auto = 0, m_lock = 0, m_dbgq = 0;
    bit [5:0] m_oen = 6'b001001;
    bit [3:0] m_en = 4'b0011, m_flags = '0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = '{0, 0, 0}; m_cnt = '{0, 0, 0}; m_pc = 0; m_presc = 0;
            m_rise = 0; m_fall = 0; m_act = 1; m_al = 0; m_ci = 0; m_alt = 0;
            m_auto = 0; m_lock = 0; m_dbgq = 0; m_oen = 6'b001001; m_en = 4'b0011;
            m_flags = '0;
        end else begin
            int  eff;
            bit  tk, d;
            bit [3:0] srcs;
            eff = (m_presc > 10) ? 10 : m_presc;
            tk  = (m_pc >= (1 << eff) - 1);
            for (int i = 0; i < 3; i++) begin
                d = (i == 0 && m_alt) ? alt_in : pwm_in[i];
                case (m_st[i])
                    0: if (d) begin
                        if (m_rise == 0) m_st[i] = 2; else begin m_st[i] = 1; m_cnt[i] = m_rise; end
                    end
                    1: if (!d) m_st[i] = 0;
                       else if (tk) begin if (m_cnt[i] == 1) m_st[i] = 2; else m_cnt[i]--; end
                    2: if (!d) begin
                        if (m_fall == 0) m_st[i] = 0; else begin m_st[i] = 3; m_cnt[i] = m_fall; end
                    end
                    default: if (d) m_st[i] = 2;
                       else if (tk) begin if (m_cnt[i] == 1) m_st[i] = 0; else m_cnt[i]--; end
                endcase
            end
            m_pc = tk ? 0 : m_pc + 1;
            srcs = {ext_fault, dbg_halt, core_lockup};
            m_flags = (m_flags & ~(flag_clr_we ? flag_clr_mask : 4'b0)) | (srcs & m_en);
            if (m_auto && m_dbgq && !dbg_halt) m_flags[1] = 1'b0;
            m_dbgq = dbg_halt;
            if (cfg_we && !m_lock) begin
                m_presc = cfg_presc; m_rise = cfg_rise; m_fall = cfg_fall; m_al = cfg_act_low;
                m_ci = cfg_cinv; m_alt = cfg_alt_sel; m_oen = cfg_oen; m_en = cfg_src_en;
                m_act = cfg_fault_act; m_auto = cfg_auto_restart;
            end
            if (key_we && key_val == LK) m_lock = 1;
            else if (key_we && key_val == UK) m_lock = 0;
        end
    end

    function automatic void model_pins(output bit [5:0] eo, output bit [5:0] eoe);
        bit fon;
        fon = (m_flags != 0) && (m_act != 0);
        for (int i = 0; i < 3; i++) begin
            bit p, n, pv, nv, op, on;
            p = (m_st[i] == 2); n = (m_st[i] == 0);
            if (fon && m_act == 1) begin p = 0; n = 0; end
            pv = p ^ m_al; nv = n ^ m_al ^ m_ci;
            if (fon && m_act == 2) begin pv = 0; nv = 0; end
            op = m_oen[i]; on = m_oen[i+3];
            if (fon && m_act == 3) begin op = 0; on = 0; end
            eo[i] = pv & op; eo[i+3] = nv & on; eoe[i] = op; eoe[i+3] = on;
        end
    endfunction

    always @(negedge clk) begin
        if (rst_n) begin
            bit [5:0] eo, eoe;
            model_pins(eo, eoe);
            vectors++;
            if (pin_o !== eo || pin_oe !== eoe || fault_flags !== m_flags) begin
                miscompares++;
                $display("FAIL %s t=%0t pin_o=%b/%b pin_oe=%b/%b flags=%b/%b (actual/expected)",
                         phase, $time, pin_o, eo, pin_oe, eoe, fault_flags, m_flags);
            end
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cfg(int ps, int rs, int fl, bit al, bit ci, bit alt, bit [5:0] oe,
                       bit [3:0] en, int act, bit ar);
        cfg_presc = 4'(ps); cfg_rise = 8'(rs); cfg_fall = 8'(fl); cfg_act_low = al;
        cfg_cinv = ci; cfg_alt_sel = alt; cfg_oen = oe; cfg_src_en = en;
        cfg_fault_act = 2'(act); cfg_auto_restart = ar; cfg_we = 1'b1;
        cyc(1);
        cfg_we = 1'b0;
    endtask

    task automatic key(logic [15:0] v);
        key_val = v; key_we = 1'b1; cyc(1); key_we = 1'b0;
    endtask

    task automatic clr(logic [3:0] m);
        flag_clr_mask = m; flag_clr_we = 1'b1; cyc(1); flag_clr_we = 1'b0;
    endtask

    logic [15:0] lfsr = 16'hACE1;
    task automatic wiggle(int n, int hold);
        for (int k = 0; k < n; k++) begin
            if (k % hold == 0) begin
                lfsr   = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                pwm_in = lfsr[2:0];
                alt_in = lfsr[7];
            end
            cyc(1);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: run did not finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        cyc(4);
        rst_n = 1'b1;
        cyc(2);
        // R1: idle pair 0 only, no flags
        chk("R1", {26'b0, pin_o}, 32'b001000);
        chk("R1", {26'b0, pin_oe}, 32'b001001);
        chk("R1", {28'b0, fault_flags}, 32'h0);

        phase = "R2";
        cfg(0, 3, 2, 0, 0, 0, 6'h3F, 4'b0011, 1, 0);
        pwm_in = '0; cyc(12);
        pwm_in[0] = 1'b1; cyc(1);
        chk("R2", {30'b0, pin_o[3], pin_o[0]}, 32'b00);
        cyc(1); chk("R2", {31'b0, pin_o[0]}, 32'b0);
        cyc(1); chk("R2", {31'b0, pin_o[0]}, 32'b0);
        cyc(1); chk("R2", {30'b0, pin_o[3], pin_o[0]}, 32'b01);
        phase = "R3";
        pwm_in[0] = 1'b0; cyc(1);
        chk("R3", {30'b0, pin_o[3], pin_o[0]}, 32'b00);
        cyc(1); chk("R3", {31'b0, pin_o[3]}, 32'b0);
        cyc(1); chk("R3", {30'b0, pin_o[3], pin_o[0]}, 32'b10);
        wiggle(200, 7); wiggle(200, 13);

        phase = "R4";
        cfg(0, 5, 4, 0, 0, 0, 6'h3F, 4'b0011, 1, 0);
        pwm_in = '0; cyc(10);
        pwm_in[0] = 1'b1;
        repeat (3) begin cyc(1); chk("R4", {31'b0, pin_o[0]}, 32'b0); end
        pwm_in[0] = 1'b0;
        repeat (6) begin cyc(1); chk("R4", {31'b0, pin_o[0]}, 32'b0); end
        wiggle(150, 2); wiggle(100, 1);

        phase = "R5";
        cfg(2, 2, 3, 0, 0, 0, 6'h3F, 4'b0011, 1, 0);
        wiggle(300, 11);
        cfg(10, 1, 1, 0, 0, 0, 6'h3F, 4'b0011, 1, 0);
        wiggle(4000, 900);
        cfg(15, 1, 1, 0, 0, 0, 6'h3F, 4'b0011, 1, 0);
        wiggle(2500, 700);

        phase = "R6";
        cfg(0, 2, 2, 1, 1, 0, 6'h3F, 4'b0011, 1, 0);
        wiggle(200, 5);
        cfg(0, 2, 2, 1, 0, 0, 6'h3F, 4'b0011, 1, 0);
        wiggle(100, 6);
        cfg(0, 2, 2, 0, 1, 0, 6'h3F, 4'b0011, 1, 0);
        wiggle(100, 4);

        phase = "R7";
        cfg(0, 1, 1, 0, 0, 0, 6'b010100, 4'b0011, 1, 0);
        wiggle(150, 5);
        chk("R7", {26'b0, pin_oe}, 32'b010100);

        phase = "R12";
        cfg(0, 1, 2, 0, 0, 1, 6'h3F, 4'b0011, 1, 0);
        wiggle(200, 6);

        phase = "R9";
        for (int a = 0; a < 4; a++) begin
            cfg(0, 1, 1, a[0], 0, 0, 6'h3F, 4'b1111, a, 0);
            wiggle(20, 5);
            ext_fault[0] = 1'b1; cyc(1); ext_fault[0] = 1'b0;
            wiggle(30, 4);
            clr(4'hF);
            wiggle(20, 5);
        end

        phase = "R8";
        cfg(0, 1, 1, 0, 0, 0, 6'h3F, 4'b1110, 2, 0);
        core_lockup = 1'b1; cyc(3); core_lockup = 1'b0; cyc(1);
        chk("R8", {28'b0, fault_flags}, 32'h0);
        ext_fault[1] = 1'b1; cyc(2);
        clr(4'b1000); cyc(1);
        chk("R8", {28'b0, fault_flags}, 32'b1000);
        ext_fault[1] = 1'b0; cyc(5);
        chk("R8", {28'b0, fault_flags}, 32'b1000);
        clr(4'b0100); cyc(1);
        chk("R8", {28'b0, fault_flags}, 32'b1000);
        clr(4'b1000); cyc(1);
        chk("R8", {28'b0, fault_flags}, 32'h0);

        phase = "R10";
        cfg(0, 1, 1, 0, 0, 0, 6'h3F, 4'b0010, 1, 1);
        dbg_halt = 1'b1; wiggle(4, 2);
        chk("R10", {31'b0, fault_flags[1]}, 32'b1);
        dbg_halt = 1'b0; cyc(1);
        chk("R10", {31'b0, fault_flags[1]}, 32'b0);
        cfg(0, 1, 1, 0, 0, 0, 6'h3F, 4'b0010, 1, 0);
        dbg_halt = 1'b1; cyc(3); dbg_halt = 1'b0; cyc(3);
        chk("R10", {31'b0, fault_flags[1]}, 32'b1);
        clr(4'b0010); wiggle(20, 3);

        phase = "R11";
        cfg(0, 1, 1, 0, 0, 0, 6'h3F, 4'b0011, 1, 0);
        key(LK);
        cfg(0, 1, 1, 0, 0, 0, 6'h00, 4'b0011, 1, 0);
        cyc(1);
        chk("R11", {26'b0, pin_oe}, 32'h3F);
        key(16'h1234);
        cfg(0, 1, 1, 0, 0, 0, 6'h00, 4'b0011, 1, 0);
        cyc(1);
        chk("R11", {26'b0, pin_oe}, 32'h3F);
        key(UK);
        cfg(0, 1, 1, 0, 0, 0, 6'b000111, 4'b0011, 1, 0);
        cyc(1);
        chk("R11", {26'b0, pin_oe}, 32'b000111);
        wiggle(100, 5);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule